// File: doc/BRIEF.md
# Keyed Diagnostic Unlock Sequencer

This block protects a diagnostic register behind an ordered key sequence. Software opens the register by writing five keys, one after another, to a separate sequence register. The block compares only the low key field of each write. It tracks how far the sequence has progressed. When the fifth correct key arrives, it raises a diagnostic-write-enable flag.

A wrong key relocks the register and sends the sequence back to its start. Any write to the sequence register while the flag is up does the same. The flag is therefore a one-shot permission: software unlocks, does its diagnostic work, then writes anything to the sequence register to lock again.

The diagnostic register can be read at any time. Writing it with the adapter-reset bit set produces a one-cycle hard-reset pulse for the rest of the chip. The same write clears the flag and the sequence position.

Top module: `diag_unlock_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `diag_rd_data` reads 0x00 and `hard_rst_pulse` is low. Asserting reset clears the flag at once, without waiting for a clock edge.
- R2: Only bits [3:0] of a sequence write form the key. Bits above them have no effect on matching.
- R3: The five keys are 0x4, 0xB, 0x2, 0x7 and 0xD, in that order. The flag rises on the cycle after the fifth correct key is written, and not earlier.
- R4: A key that differs from the one expected at the current position returns the position to the first key and leaves the flag clear. A new attempt must start again from 0x4.
- R5: Any sequence write made while the flag is set clears the flag and returns the position to the first key, even if the value written equals the first key.
- R6: A diagnostic write with bit 2 set makes `hard_rst_pulse` high for exactly the following cycle. Consecutive such writes give consecutive pulses.
- R7: A diagnostic write with bit 2 clear produces no pulse and changes neither the flag nor the position. This holds even when the other bits, including bit 7, are set.
- R8: A hard-reset write clears the flag and the sequence position on the same edge that launches the pulse.
- R9: When a sequence write and a hard-reset write arrive in the same cycle, the hard reset wins and the key is discarded.
- R10: `diag_rd_data` shows the flag in bit 7 and reads zero in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| seq_wr_en | input | 1 | Write strobe for the sequence register |
| seq_wr_data | input | DATA_W | Sequence register write data; the key is in bits [3:0] |
| diag_wr_en | input | 1 | Write strobe for the diagnostic register |
| diag_wr_data | input | DATA_W | Diagnostic register write data; bit 2 requests a hard reset |
| diag_rd_data | output | DATA_W | Diagnostic register read value; bit 7 is the write-enable flag |
| hard_rst_pulse | output | 1 | One-cycle hard-reset request |

## Verification
A sequence-register write and a hard-reset diagnostic write can land on the same clock edge. Each one tries to move the position and the flag in a different direction.

The bench provokes this collision with the fifth key pending, so that without the hard reset the key would unlock. It checks three things: the pulse appears, the flag stays clear, and a lone fifth key written next does not unlock, which shows that the position really went back to the start.

A second collision-like case follows a hard reset with a full sequence. It confirms that the sequence tracker resumes cleanly.

// File: rtl/diag_unlock_pkg.sv
package diag_unlock_pkg;
  localparam int KEY_W    = 4;
  localparam int NUM_KEYS = 5;

  typedef logic [KEY_W-1:0] key_t;

  // expected key per sequence position, position 0 first
  localparam key_t KEY_TABLE [NUM_KEYS] = '{4'h4, 4'hB, 4'h2, 4'h7, 4'hD};
endpackage

// File: rtl/dus_rst_sync.sv
module dus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dus_key_check.sv
module dus_key_check
  import diag_unlock_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  logic [POS_W-1:0] pos,
  input  key_t             key,
  output logic             match
);
  logic [NUM_KEYS-1:0] hit;

  for (genvar gi = 0; gi < NUM_KEYS; gi++) begin : g_slot
    assign hit[gi] = (pos == POS_W'(gi)) && (key == KEY_TABLE[gi]);
  end

  assign match = |hit;
endmodule

// File: rtl/dus_seq_tracker.sv
module dus_seq_tracker
  import diag_unlock_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             key_match,
  input  logic             hard_clr,
  output logic [POS_W-1:0] pos_q,
  output logic             unlocked_q
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_KEYS - 1);

  logic [POS_W-1:0] pos_d;
  logic             unlocked_d;
  logic             upd;

  assign upd = hard_clr | wr_en;

  always_comb begin
    pos_d      = pos_q;
    unlocked_d = unlocked_q;
    if (hard_clr) begin
      pos_d      = '0;
      unlocked_d = 1'b0;
    end else if (wr_en) begin
      if (unlocked_q || !key_match) begin
        pos_d      = '0;
        unlocked_d = 1'b0;
      end else begin
        pos_d = pos_q + 1'b1;
        if (pos_q == LAST_POS) unlocked_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      unlocked_q <= 1'b0;
    end else if (upd) begin
      pos_q      <= pos_d;
      unlocked_q <= unlocked_d;
    end
  end

  // R3: unlocking only ever follows the last key position
  p_unlock_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> ($past(pos_q) == LAST_POS && $past(wr_en)));

  // R4: a mismatching key sends the sequence back to its start
  p_mismatch_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked_q && !key_match) |=> (pos_q == '0 && !unlocked_q));

  // R4: position stays within the key range plus one
  p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= POS_W'(NUM_KEYS));

  // R5: any write while unlocked relocks
  p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && unlocked_q) |=> (!unlocked_q && pos_q == '0));
endmodule

// File: rtl/dus_pulse_gen.sv
module dus_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic rst_bit,
  output logic clr_req,
  output logic pulse_q
);
  logic pulse_d;

  assign clr_req = wr_en & rst_bit;
  assign pulse_d = clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  // R6: a pulse is always caused by a reset-bit write one cycle earlier
  p_pulse_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(wr_en && rst_bit));

  // R7: a diagnostic write without the reset bit never pulses
  p_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rst_bit) |=> !pulse_q);
endmodule

// File: rtl/diag_unlock_seq.sv
module diag_unlock_seq
  import diag_unlock_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EN_BIT  = 7,
  parameter int RST_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_wr_en,
  input  logic [DATA_W-1:0] seq_wr_data,
  input  logic              diag_wr_en,
  input  logic [DATA_W-1:0] diag_wr_data,
  output logic [DATA_W-1:0] diag_rd_data,
  output logic              hard_rst_pulse
);
  localparam int POS_W = $clog2(NUM_KEYS + 1);

  logic             rst_sync_n;
  logic             key_match;
  logic             hard_clr;
  logic             unlocked;
  logic [POS_W-1:0] pos;
  logic             unused_bits;

  assign unused_bits = ^{seq_wr_data[DATA_W-1:KEY_W], diag_wr_data};

  dus_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dus_key_check #(.POS_W(POS_W)) u_key_check (
    .pos   (pos),
    .key   (seq_wr_data[KEY_W-1:0]),
    .match (key_match)
  );

  dus_pulse_gen u_pulse_gen (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (diag_wr_en),
    .rst_bit (diag_wr_data[RST_BIT]),
    .clr_req (hard_clr),
    .pulse_q (hard_rst_pulse)
  );

  dus_seq_tracker #(.POS_W(POS_W)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (seq_wr_en),
    .key_match  (key_match),
    .hard_clr   (hard_clr),
    .pos_q      (pos),
    .unlocked_q (unlocked)
  );

  always_comb begin
    diag_rd_data         = '0;
    diag_rd_data[EN_BIT] = unlocked;
  end

  // R8: the pulse cycle always sees the flag already cleared
  p_pulse_clears_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hard_rst_pulse |-> (!unlocked && pos == '0));

  // R9: a colliding sequence write loses to the hard reset
  p_collision_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seq_wr_en && diag_wr_en && diag_wr_data[RST_BIT]) |=> (pos == '0 && !unlocked));
endmodule

// File: tb/diag_unlock_seq_bench.sv
module diag_unlock_seq_bench;
  logic       clk;
  logic       rst_n;
  logic       seq_wr_en;
  logic [7:0] seq_wr_data;
  logic       diag_wr_en;
  logic [7:0] diag_wr_data;
  logic [7:0] diag_rd_data;
  logic       hard_rst_pulse;

  int checks = 0;
  int errors = 0;

  diag_unlock_seq u_diag_unlock_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .seq_wr_en      (seq_wr_en),
    .seq_wr_data    (seq_wr_data),
    .diag_wr_en     (diag_wr_en),
    .diag_wr_data   (diag_wr_data),
    .diag_rd_data   (diag_rd_data),
    .hard_rst_pulse (hard_rst_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {req[3:0], seq_v, diag_v, seq_d[7:0], diag_d[7:0], exp_rd[7:0], exp_pulse}
  function automatic logic [30:0] mk(input int r, input bit sv, input bit dv,
                                     input logic [7:0] sd, input logic [7:0] dd,
                                     input logic [7:0] er, input bit ep);
    return {4'(r), sv, dv, sd, dd, er, ep};
  endfunction

  localparam int NV = 45;
  localparam logic [30:0] VEC [NV] = '{
    mk(1, 0, 0, 8'h00, 8'h00, 8'h00, 0),  // R1 idle after reset
    mk(2, 1, 0, 8'hF4, 8'h00, 8'h00, 0),  // R2 upper bits ignored
    mk(2, 1, 0, 8'h3B, 8'h00, 8'h00, 0),  // R2
    mk(3, 1, 0, 8'h02, 8'h00, 8'h00, 0),  // R3
    mk(3, 1, 0, 8'h07, 8'h00, 8'h00, 0),  // R3 not yet unlocked
    mk(3, 1, 0, 8'h0D, 8'h00, 8'h80, 0),  // R3 fifth key unlocks
    mk(7, 0, 1, 8'h00, 8'h00, 8'h80, 0),  // R7 diag write, no reset bit
    mk(10, 0, 0, 8'h00, 8'h00, 8'h80, 0), // R10 flag at bit 7 only
    mk(5, 1, 0, 8'h04, 8'h00, 8'h00, 0),  // R5 write while unlocked relocks
    mk(5, 1, 0, 8'h0B, 8'h00, 8'h00, 0),  // R5 position back at 0
    mk(5, 1, 0, 8'h04, 8'h00, 8'h00, 0),
    mk(5, 1, 0, 8'h0B, 8'h00, 8'h00, 0),
    mk(5, 1, 0, 8'h02, 8'h00, 8'h00, 0),
    mk(5, 1, 0, 8'h07, 8'h00, 8'h00, 0),
    mk(5, 1, 0, 8'h0D, 8'h00, 8'h80, 0),  // R5 fresh sequence unlocks
    mk(8, 0, 1, 8'h00, 8'h04, 8'h00, 1),  // R8 R6 hard reset clears flag
    mk(6, 0, 0, 8'h00, 8'h00, 8'h00, 0),  // R6 pulse is one cycle
    mk(4, 1, 0, 8'h04, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h0B, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h04, 8'h00, 8'h00, 0),  // R4 mismatch at position 2
    mk(4, 1, 0, 8'h0B, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h02, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h07, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h0D, 8'h00, 8'h00, 0),  // R4 no unlock without restart
    mk(4, 1, 0, 8'h04, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h0B, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h02, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h07, 8'h00, 8'h00, 0),
    mk(4, 1, 0, 8'h0D, 8'h00, 8'h80, 0),  // R4 restart from first key works
    mk(7, 0, 1, 8'h00, 8'hFB, 8'h80, 0),  // R7 all bits but reset bit
    mk(5, 1, 0, 8'h00, 8'h00, 8'h00, 0),  // R5 relock by any value
    mk(9, 1, 0, 8'h04, 8'h00, 8'h00, 0),
    mk(9, 1, 0, 8'h0B, 8'h00, 8'h00, 0),
    mk(9, 1, 0, 8'h02, 8'h00, 8'h00, 0),
    mk(9, 1, 0, 8'h07, 8'h00, 8'h00, 0),
    mk(9, 1, 1, 8'h0D, 8'h04, 8'h00, 1),  // R9 collision: reset wins
    mk(9, 1, 0, 8'h0D, 8'h00, 8'h00, 0),  // R9 key was discarded
    mk(8, 1, 0, 8'h04, 8'h00, 8'h00, 0),
    mk(8, 1, 0, 8'h0B, 8'h00, 8'h00, 0),
    mk(8, 1, 0, 8'h02, 8'h00, 8'h00, 0),
    mk(8, 1, 0, 8'h07, 8'h00, 8'h00, 0),
    mk(8, 1, 0, 8'h0D, 8'h80, 8'h80, 0),  // R8 tracker resumes after reset
    mk(6, 0, 1, 8'h00, 8'h04, 8'h00, 1),  // R6
    mk(6, 0, 1, 8'h00, 8'h04, 8'h00, 1),  // R6 back-to-back pulses
    mk(6, 0, 0, 8'h00, 8'h00, 8'h00, 0)   // R6 pulse ends
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic seq_put(input logic [7:0] d);
    seq_wr_en = 1'b1; seq_wr_data = d;
    @(negedge clk);
    seq_wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; seq_wr_en = 1'b0; seq_wr_data = '0;
    diag_wr_en = 1'b0; diag_wr_data = '0;
    repeat (3) @(negedge clk);
    check(1, diag_rd_data, 8'h00, "read during reset");           // R1
    check(1, {7'd0, hard_rst_pulse}, 8'h00, "pulse during reset"); // R1
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      seq_wr_en    = v[26];
      diag_wr_en   = v[25];
      seq_wr_data  = v[24:17];
      diag_wr_data = v[16:9];
      @(negedge clk);
      seq_wr_en  = 1'b0;
      diag_wr_en = 1'b0;
      check(int'(v[30:27]), diag_rd_data, v[8:1], $sformatf("row %0d read", i));
      check(int'(v[30:27]), {7'd0, hard_rst_pulse}, {7'd0, v[0]}, $sformatf("row %0d pulse", i));
    end

    // R1: asynchronous reset while unlocked clears the flag without a clock edge
    seq_put(8'h04); seq_put(8'h0B); seq_put(8'h02); seq_put(8'h07); seq_put(8'h0D);
    check(3, diag_rd_data, 8'h80, "unlock before async reset");
    #2 rst_n = 1'b0;
    #1 check(1, diag_rd_data, 8'h00, "async reset clears flag");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: position also cleared, so a partial sequence does not unlock
    seq_put(8'h0D);
    check(1, diag_rd_data, 8'h00, "no unlock from stale position");
    seq_put(8'h04); seq_put(8'h0B); seq_put(8'h02); seq_put(8'h07);
    check(3, diag_rd_data, 8'h00, "four keys stay locked");
    seq_put(8'hAD); // R2 upper bits differ, key field matches
    check(2, diag_rd_data, 8'h80, "upper bits ignored on last key");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule